// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Block

This block gathers up to 32 interrupt sources behind a small word-addressed register port. Each hardware event input latches into a sticky cause bit. A mask vector then decides which latched causes may raise the single interrupt output. Software reaches the block through a simple write strobe and read strobe with a 3-bit word address. Through that port it picks, bit by bit, how each cause is retired: by writing a one to it, or by reading it. It can also force causes from software, and it can change single mask bits atomically through separate set and clear words, with no read-modify-write.

The interrupt output is the registered OR of all unmasked cause bits. An interrupt handler typically reads the masked-cause word to learn which sources need service. It then retires them in the way the clear-mode word selects for each bit.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After synchronous reset, every cause bit is 0, every mask bit is 1, the clear-mode word is 0, the interrupt output is 0 and the read data is 0.
- R2: An event input bit that is 1 at a clock edge sets the matching cause bit at that edge, and the bit stays set until it is cleared.
- R3: A write to word 1 (cause) or word 2 (masked cause) clears each cause bit whose clear-mode bit is 0 and whose write-data bit is 1. Write-data bits of 0, and bits whose clear-mode bit is 1, are left unchanged.
- R4: A read of word 1 returns the whole cause vector. In the same cycle it clears every cause bit that is 1 and whose clear-mode bit is 1. Bits whose clear-mode bit is 0 are not changed by the read.
- R5: A read of word 2 returns cause AND NOT mask. It clears only the clear-mode-1 bits that it returned as 1, so masked cause bits survive the read.
- R6: A write to word 3 (force) sets each cause bit whose write-data bit is 1. Zero bits have no effect, and a read of word 3 returns 0.
- R7: Word 4 (mask) is read and written as a whole. Writing a 1 to a bit of word 5 sets that mask bit, and writing a 1 to a bit of word 6 clears that mask bit. Zero bits of words 5 and 6 have no effect, and reads of words 5 and 6 return 0.
- R8: When a cause bit is set by an event and cleared by software in the same cycle, whether by a write or by a read, it ends up set.
- R9: The interrupt output is 1 exactly one clock after a cycle in which some cause bit is 1 with its mask bit 0, and it is 0 one clock after no such bit exists.
- R10: The word map is 0 clear-mode, 1 cause, 2 masked cause, 3 force, 4 mask, 5 mask-set, 6 mask-clear. A read with the read strobe at an edge places the word on the read data at that edge, and the value holds until the next read. Word 0 reads back what was written to it, and word 7 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one word per cycle |
| rd_en | input | 1 | Register read strobe, a completed read per cycle |
| addr | input | 3 | Word address |
| wdata | input | N_SRC | Write data |
| rdata | output | N_SRC | Registered read data |
| event_i | input | N_SRC | Hardware event inputs, sampled every clock |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench aims at how read and write clearing interact under a mixed clear-mode word. A design that ignored the mode bits would wipe clear-on-read causes when software writes ones to them, or would leave them set after a read. It also checks that a masked-cause read clears only the bits it returned; a design that cleared all clear-on-read bits would lose pending masked events. Events that arrive in the very cycle of a clearing write or read are aimed at the set-wins rule, which a wrong priority would break by losing an event. The interrupt output is sampled in the cycle before and the cycle of its expected change, to expose an extra or missing register stage.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int ADDR_W    = 3;
  localparam int REG_COUNT = 7;

  typedef enum logic [ADDR_W-1:0] {
    REG_CLRMODE  = 3'd0,
    REG_CAUSE    = 3'd1,
    REG_MCAUSE   = 3'd2,
    REG_FORCE    = 3'd3,
    REG_MASK     = 3'd4,
    REG_MASK_SET = 3'd5,
    REG_MASK_CLR = 3'd6,
    REG_NONE     = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_cause_pkg::*;
(
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  output logic [REG_COUNT-1:0] wr_strb,
  output logic                 rd_cause,
  output logic                 rd_mcause
);
  // one write strobe per implemented word; word 7 decodes to nothing
  for (genvar g = 0; g < REG_COUNT; g++) begin : g_wr
    assign wr_strb[g] = wr_en && (addr == ADDR_W'(g));
  end

  assign rd_cause  = rd_en && (addr == REG_CAUSE);
  assign rd_mcause = rd_en && (addr == REG_MCAUSE);
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_clrmode,
  input  logic             wr_mask,
  input  logic             wr_mask_set,
  input  logic             wr_mask_clr,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] clrmode_o,
  output logic [N_SRC-1:0] mask_o
);
  logic [N_SRC-1:0] clrmode_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] mask_d;

  always_ff @(posedge clk) begin
    if (rst) clrmode_q <= '0;
    else if (wr_clrmode) clrmode_q <= wdata;
  end

  always_comb begin
    mask_d = mask_q;
    if (wr_mask)     mask_d = wdata;
    if (wr_mask_set) mask_d = mask_q | wdata;
    if (wr_mask_clr) mask_d = mask_q & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else     mask_q <= mask_d;
  end

  assign clrmode_o = clrmode_q;
  assign mask_o    = mask_q;
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] event_i,
  input  logic             wr_force,
  input  logic             wr_retire,
  input  logic             rd_cause,
  input  logic             rd_mcause,
  input  logic [N_SRC-1:0] wdata,
  input  logic [N_SRC-1:0] clrmode,
  input  logic [N_SRC-1:0] mask,
  output logic [N_SRC-1:0] cause_o
);
  logic [N_SRC-1:0] cause_q;

  for (genvar b = 0; b < N_SRC; b++) begin : g_bit
    logic set_b;
    logic clr_b;
    // software force and hardware events share the set path
    assign set_b = event_i[b] | (wr_force & wdata[b]);
    // clear by write for mode 0, by completed read for mode 1
    assign clr_b = (wr_retire & wdata[b] & ~clrmode[b])
                 | (rd_cause & clrmode[b])
                 | (rd_mcause & clrmode[b] & ~mask[b]);

    always_ff @(posedge clk) begin
      if (rst)        cause_q[b] <= 1'b0;
      else if (set_b) cause_q[b] <= 1'b1;
      else if (clr_b) cause_q[b] <= 1'b0;
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_cause_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_SRC-1:0]  clrmode,
  input  logic [N_SRC-1:0]  cause,
  input  logic [N_SRC-1:0]  mask,
  output logic [N_SRC-1:0]  rdata_o
);
  logic [N_SRC-1:0] sel_d;
  logic [N_SRC-1:0] rdata_q;

  always_comb begin
    case (reg_sel_e'(addr))
      REG_CLRMODE: sel_d = clrmode;
      REG_CAUSE:   sel_d = cause;
      REG_MCAUSE:  sel_d = cause & ~mask;
      REG_MASK:    sel_d = mask;
      default:     sel_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= sel_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_SRC-1:0]  wdata,
  output logic [N_SRC-1:0]  rdata,
  input  logic [N_SRC-1:0]  event_i,
  output logic              irq_o
);
  logic [REG_COUNT-1:0] wr_strb;
  logic                 rd_cause;
  logic                 rd_mcause;
  logic [N_SRC-1:0]     clrmode_q;
  logic [N_SRC-1:0]     mask_q;
  logic [N_SRC-1:0]     cause_q;
  logic                 irq_q;

  irq_reg_decode u_dec (
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wr_strb   (wr_strb),
    .rd_cause  (rd_cause),
    .rd_mcause (rd_mcause)
  );

  irq_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .wr_clrmode  (wr_strb[REG_CLRMODE]),
    .wr_mask     (wr_strb[REG_MASK]),
    .wr_mask_set (wr_strb[REG_MASK_SET]),
    .wr_mask_clr (wr_strb[REG_MASK_CLR]),
    .wdata       (wdata),
    .clrmode_o   (clrmode_q),
    .mask_o      (mask_q)
  );

  irq_cause_bank #(.N_SRC(N_SRC)) u_cause (
    .clk       (clk),
    .rst       (rst),
    .event_i   (event_i),
    .wr_force  (wr_strb[REG_FORCE]),
    .wr_retire (wr_strb[REG_CAUSE] | wr_strb[REG_MCAUSE]),
    .rd_cause  (rd_cause),
    .rd_mcause (rd_mcause),
    .wdata     (wdata),
    .clrmode   (clrmode_q),
    .mask      (mask_q),
    .cause_o   (cause_q)
  );

  irq_read_mux #(.N_SRC(N_SRC)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .addr    (addr),
    .clrmode (clrmode_q),
    .cause   (cause_q),
    .mask    (mask_q),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(cause_q & ~mask_q);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_cause_ctrl_chk.sv
module irq_cause_ctrl_chk
  import irq_cause_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N_SRC-1:0]  wdata,
  input logic [N_SRC-1:0]  rdata,
  input logic [N_SRC-1:0]  event_i,
  input logic              irq_o,
  input logic [N_SRC-1:0]  cause_q,
  input logic [N_SRC-1:0]  mask_q,
  input logic [N_SRC-1:0]  clrmode_q
);
  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (rst)
    (event_i != '0) |=> ((cause_q & $past(event_i)) == $past(event_i))); // R8

  AST_IRQ_DELAY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(cause_q & ~mask_q)))); // R9

  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_MASK_SET) |=> ((mask_q & $past(wdata)) == $past(wdata))); // R7

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_MASK_CLR) |=> ((mask_q & $past(wdata)) == '0)); // R7

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == REG_FORCE || addr == REG_MASK_SET ||
               addr == REG_MASK_CLR || addr == REG_NONE)) |=> (rdata == '0)); // R6

  AST_MCAUSE_VIEW: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == REG_MCAUSE) |=> (rdata == $past(cause_q & ~mask_q))); // R5

  AST_COR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == REG_CAUSE && !wr_en && event_i == '0)
      |=> ((cause_q & $past(clrmode_q & cause_q)) == '0)); // R4

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_en) |=> $stable(rdata)); // R10
endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk #(.N_SRC(N_SRC)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .event_i   (event_i),
  .irq_o     (irq_o),
  .cause_q   (cause_q),
  .mask_q    (mask_q),
  .clrmode_q (clrmode_q)
);

// File: tb/irq_cause_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_cause_ctrl_tb_top;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic [N-1:0] event_i = '0;
  logic         irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [N-1:0] exp_q[$];
  string        tag_q[$];
  logic         rd_seen = 1'b0;

  always #4 clk = ~clk;

  irq_cause_ctrl #(.N_SRC(N)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .event_i(event_i), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [N-1:0] d, input logic [N-1:0] ev);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; event_i = ev;
    @(negedge clk);
    wr_en = 1'b0; event_i = '0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic [N-1:0] exp,
                        input logic [N-1:0] ev, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a; event_i = ev;
    @(negedge clk);
    rd_en = 1'b0; event_i = '0;
  endtask

  task automatic pulse(input logic [N-1:0] ev);
    @(negedge clk);
    event_i = ev;
    @(negedge clk);
    event_i = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares each completed read against the scoreboard queue
  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", rdata, 'x);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 irq during reset", {31'd0, irq_o}, '0);
    check("R1 rdata during reset", rdata, '0);
    rst = 1'b0;

    // R1 reset state
    bus_rd(3'd0, 32'h0, '0, "R1 clear-mode reset");
    bus_rd(3'd1, 32'h0, '0, "R1 cause reset");
    bus_rd(3'd4, 32'hFFFF_FFFF, '0, "R1 mask reset");
    check("R1 irq after reset", {31'd0, irq_o}, '0);

    // R2 events latch, masked view hides them
    pulse(32'h0000_00F0);
    bus_rd(3'd1, 32'h0000_00F0, '0, "R2 event latched");
    bus_rd(3'd2, 32'h0, '0, "R5 masked view all masked");
    check("R9 irq stays low while masked", {31'd0, irq_o}, '0);

    // R3 write-one-to-clear
    bus_wr(3'd1, 32'h0000_0030, '0);
    bus_rd(3'd1, 32'h0000_00C0, '0, "R3 w1c clears written ones only");

    // R7 and R9 mask clear / set
    bus_wr(3'd6, 32'h0000_0080, '0);
    check("R9 irq not yet high", {31'd0, irq_o}, '0);
    idle(1);
    check("R9 irq high one cycle later", {31'd0, irq_o}, 32'd1);
    bus_rd(3'd4, 32'hFFFF_FF7F, '0, "R7 mask-clear");
    bus_rd(3'd2, 32'h0000_0080, '0, "R5 masked view unmasked bit");
    bus_rd(3'd5, 32'h0, '0, "R7 mask-set reads zero");
    bus_rd(3'd6, 32'h0, '0, "R7 mask-clear reads zero");
    bus_wr(3'd5, 32'h0000_0080, '0);
    check("R9 irq still high", {31'd0, irq_o}, 32'd1);
    idle(1);
    check("R9 irq low after mask-set", {31'd0, irq_o}, '0);

    // R4 clear-on-read
    bus_wr(3'd0, 32'h0000_0F00, '0);
    bus_rd(3'd0, 32'h0000_0F00, '0, "R10 clear-mode readback");
    pulse(32'h0000_0300);
    bus_rd(3'd1, 32'h0000_03C0, '0, "R4 read returns all causes");
    bus_rd(3'd1, 32'h0000_00C0, '0, "R4 read cleared only mode-1 bits");
    pulse(32'h0000_0100);
    bus_wr(3'd1, 32'h0000_01C0, '0);
    bus_rd(3'd1, 32'h0000_0100, '0, "R3 write ignores clear-on-read bit");
    bus_rd(3'd1, 32'h0000_0000, '0, "R4 second read empty");

    // R5 masked-cause read clears only returned bits
    pulse(32'h0000_0600);
    bus_wr(3'd6, 32'h0000_0200, '0);
    idle(1);
    check("R9 irq for unmasked bit 9", {31'd0, irq_o}, 32'd1);
    bus_rd(3'd2, 32'h0000_0200, '0, "R5 masked read value");
    check("R9 irq still high at read edge", {31'd0, irq_o}, 32'd1);
    idle(1);
    check("R9 irq falls after masked read", {31'd0, irq_o}, '0);
    bus_rd(3'd1, 32'h0000_0400, '0, "R5 masked bit survived");
    bus_rd(3'd1, 32'h0000_0000, '0, "R4 cleared by cause read");
    bus_wr(3'd4, 32'hFFFF_FFFF, '0);
    bus_rd(3'd4, 32'hFFFF_FFFF, '0, "R7 mask direct write");

    // R6 force
    bus_wr(3'd3, 32'h0001_0000, '0);
    bus_rd(3'd1, 32'h0001_0000, '0, "R6 force sets");
    bus_wr(3'd3, 32'h0, '0);
    bus_rd(3'd1, 32'h0001_0000, '0, "R6 force zero no effect");
    bus_rd(3'd3, 32'h0, '0, "R6 force reads zero");
    bus_wr(3'd1, 32'h0001_0000, '0);
    bus_rd(3'd1, 32'h0, '0, "R3 clear forced bit");

    // R8 set wins
    pulse(32'h0002_0000);
    bus_wr(3'd1, 32'h0002_0000, 32'h0002_0000);
    bus_rd(3'd1, 32'h0002_0000, '0, "R8 event beats write clear");
    pulse(32'h0000_0800);
    bus_rd(3'd1, 32'h0002_0800, 32'h0000_0800, "R8 read with event");
    bus_rd(3'd1, 32'h0002_0800, '0, "R8 event beats read clear");
    bus_rd(3'd1, 32'h0002_0000, '0, "R4 later read clears");
    bus_wr(3'd1, 32'h0002_0000, '0);
    bus_rd(3'd1, 32'h0, '0, "R3 final clear");

    // R10 unused word
    bus_wr(3'd7, 32'hFFFF_FFFF, '0);
    bus_rd(3'd7, 32'h0, '0, "R10 word 7 reads zero");
    bus_rd(3'd0, 32'h0000_0F00, '0, "R10 word 7 write ignored clear-mode");
    bus_rd(3'd4, 32'hFFFF_FFFF, '0, "R10 word 7 write ignored mask");
    bus_rd(3'd1, 32'h0, '0, "R10 word 7 write ignored cause");
    idle(2);
    check("R10 rdata holds last read", rdata, 32'h0);
    check("scoreboard drained", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule